// File: doc/BRIEF.md
# Ethernet Receive Frame Status Classifier

This block sits behind an Ethernet receive MAC and handles each frame once it has ended. For every end-of-frame record it gets the byte count (FCS included) and a CRC-good flag. From these it decides whether the frame is silently thrown away. For a frame it keeps, it works out which status conditions apply: good, CRC error, runt or oversize. It also gives the length to be stored, which counts the four FCS bytes only when the configuration asks for them. Kept frames leave as one result item on a valid/ready stream.

A 16-bit configuration register holds the interrupt enable for each condition and the FCS-keep option. Writing a 1 to its skip bit issues a one-cycle command, `skip_pulse`, that tells the buffer logic to delete the most recently committed frame. The status of the last kept frame is held in a status word. A level interrupt collects every enabled condition and stays asserted until the host reads the status word.

Back-pressure rules: `eof_ready` is high whenever the single output register is empty or is being drained in the same cycle. An end-of-frame record is consumed on a clock edge where `eof_valid` and `eof_ready` are both high. While `out_valid` is high and `out_ready` is low, the result item is held unchanged. Status and interrupt are updated on the consuming edge, whatever the state of the output side.

Top module: `rx_status_classifier`

## Requirements
- R1: After reset the configuration reads 0x0003. Bits 5:0 always read 000011. Bits 15, 10, 9, 7 and 6 always read 0. Bits 8, 11, 12, 13 and 14 read back the value last written.
- R2: A register write with bit 6 set drives `skip_pulse` high for exactly the one cycle after the write, and the bit is not retained.
- R3: While `dma_only` is high, a write with bit 6 set produces no `skip_pulse`.
- R4: A frame of fewer than 8 bytes is consumed but yields no result item and leaves the status word and interrupt unchanged.
- R5: A kept frame of fewer than 64 bytes sets the runt flag (flag bit 2).
- R6: A frame longer than 1518 bytes sets the oversize flag (flag bit 3), whether its CRC is good or bad.
- R7: A bad CRC sets the CRC error flag (flag bit 1). A short frame with a bad CRC sets both bit 1 and bit 2.
- R8: The good flag (flag bit 0) is set only when the runt, oversize and CRC error flags are all clear.
- R9: The reported length is the byte count minus 4 when bit 11 is clear, and the byte count itself when bit 11 is set.
- R10: In the cycle after a kept frame is consumed, `sts_word` holds its flags. `irq` is high if any set flag has its enable set (good: bit 8, CRC error: bit 12, runt: bit 13, oversize: bit 14). `irq` stays high until a `sts_rd` pulse, which clears both `irq` and `sts_word`.
- R11: While `dma_mode` is high, a good frame does not raise `irq`, even with bit 8 set.
- R12: `eof_ready` is high exactly when `out_valid` is low or `out_ready` is high. A stalled result item holds its length and flags stable, and every kept frame appears on the output exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_data | output | 16 | Configuration read value |
| dma_only | input | 1 | DMA-only receive mode; blocks the skip command |
| dma_mode | input | 1 | Frames are received by DMA; masks the good-frame interrupt |
| skip_pulse | output | 1 | One-cycle command to drop the last committed frame |
| eof_valid | input | 1 | End-of-frame record valid |
| eof_ready | output | 1 | End-of-frame record accepted |
| eof_bytes | input | LEN_W | Frame byte count including FCS |
| eof_crc_ok | input | 1 | Frame CRC matched |
| out_valid | output | 1 | Result item valid |
| out_ready | input | 1 | Result item taken |
| out_len | output | LEN_W | Length to store |
| out_flags | output | 4 | {oversize, runt, crc error, good} |
| sts_rd | input | 1 | Status read strobe; clears status and interrupt |
| sts_word | output | 4 | Flags of the last kept frame |
| irq | output | 1 | Interrupt request |

## Verification
A bad threshold comparison or flag combination shows up in the flags of the very next result item and in `sts_word` one cycle after the frame is consumed. An interrupt enable that is lost or crossed shows up on `irq` in that same cycle. A stuck skip bit or a broken one-shot shows up on `skip_pulse` one cycle after the write, and again at the next configuration read. A wrong ready/hold rule shows up as a lost, doubled or changed result item when the sink stalls.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef struct packed {
    logic oversize;
    logic runt;
    logic crc_err;
    logic good;
  } rxc_flags_t;

  typedef struct packed {
    logic long_ie;
    logic runt_ie;
    logic crc_ie;
    logic keep_fcs;
    logic ok_ie;
  } rxc_cfg_t;

  localparam int unsigned CFG_W   = 16;
  localparam int unsigned ID_W    = 6;
  localparam int unsigned B_SKIP  = 6;
  localparam int unsigned B_OKIE  = 8;
  localparam int unsigned B_KEEP  = 11;
  localparam int unsigned B_CRCIE = 12;
  localparam int unsigned B_RUNTIE = 13;
  localparam int unsigned B_LONGIE = 14;
endpackage

// File: rtl/rxc_cfg_reg.sv
module rxc_cfg_reg
  import rxc_pkg::*;
#(
  parameter logic [ID_W-1:0] REG_ID = 6'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             dma_only,
  output logic [CFG_W-1:0] rd_data,
  output rxc_cfg_t         cfg,
  output logic             skip_pulse
);
  rxc_cfg_t cfg_q;
  logic     skip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= wr_en && wr_data[B_SKIP] && !dma_only;
      if (wr_en) begin
        cfg_q.ok_ie    <= wr_data[B_OKIE];
        cfg_q.keep_fcs <= wr_data[B_KEEP];
        cfg_q.crc_ie   <= wr_data[B_CRCIE];
        cfg_q.runt_ie  <= wr_data[B_RUNTIE];
        cfg_q.long_ie  <= wr_data[B_LONGIE];
      end
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[ID_W-1:0] = REG_ID;
    rd_data[B_OKIE]   = cfg_q.ok_ie;
    rd_data[B_KEEP]   = cfg_q.keep_fcs;
    rd_data[B_CRCIE]  = cfg_q.crc_ie;
    rd_data[B_RUNTIE] = cfg_q.runt_ie;
    rd_data[B_LONGIE] = cfg_q.long_ie;
  end

  assign cfg        = cfg_q;
  assign skip_pulse = skip_q;
endmodule

// File: rtl/rxc_classify.sv
module rxc_classify
  import rxc_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MIN_KEEP  = 8,
  parameter int unsigned RUNT_LIM  = 64,
  parameter int unsigned MAX_LEN   = 1518,
  parameter int unsigned FCS_BYTES = 4
) (
  input  logic [LEN_W-1:0] bytes,
  input  logic             crc_ok,
  input  logic             keep_fcs,
  output logic             drop,
  output rxc_flags_t       flags,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] KEEP_L = LEN_W'(MIN_KEEP);
  localparam logic [LEN_W-1:0] RUNT_L = LEN_W'(RUNT_LIM);
  localparam logic [LEN_W-1:0] MAX_L  = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] FCS_L  = LEN_W'(FCS_BYTES);

  always_comb begin
    drop           = bytes < KEEP_L;
    flags.runt     = bytes < RUNT_L;
    flags.oversize = bytes > MAX_L;
    flags.crc_err  = !crc_ok;
    flags.good     = !(flags.runt || flags.oversize || flags.crc_err);
    len            = keep_fcs ? bytes : bytes - FCS_L;
  end
endmodule

// File: rtl/rxc_status.sv
module rxc_status
  import rxc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  rxc_flags_t flags,
  input  rxc_flags_t enables,
  input  logic       rd,
  output rxc_flags_t word,
  output logic       irq
);
  rxc_flags_t word_q;
  rxc_flags_t pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      pend_q <= '0;
    end else if (load) begin
      word_q <= flags;
      pend_q <= rd ? (flags & enables) : (pend_q | (flags & enables));
    end else if (rd) begin
      word_q <= '0;
      pend_q <= '0;
    end
  end

  assign word = word_q;
  assign irq  = |pend_q;
endmodule

// File: rtl/rx_status_classifier.sv
module rx_status_classifier
  import rxc_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MIN_KEEP  = 8,
  parameter int unsigned RUNT_LIM  = 64,
  parameter int unsigned MAX_LEN   = 1518,
  parameter int unsigned FCS_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [15:0]      cfg_wr_data,
  output logic [15:0]      cfg_rd_data,
  input  logic             dma_only,
  input  logic             dma_mode,
  output logic             skip_pulse,
  input  logic             eof_valid,
  output logic             eof_ready,
  input  logic [LEN_W-1:0] eof_bytes,
  input  logic             eof_crc_ok,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LEN_W-1:0] out_len,
  output logic [3:0]       out_flags,
  input  logic             sts_rd,
  output logic [3:0]       sts_word,
  output logic             irq
);
  rxc_cfg_t         cfg;
  logic             drop;
  rxc_flags_t       cls_flags;
  logic [LEN_W-1:0] cls_len;
  rxc_flags_t       irq_en;
  rxc_flags_t       sts_q;
  logic             accept;
  logic             keep;
  logic             ov_q;
  logic [LEN_W-1:0] len_q;
  rxc_flags_t       flg_q;

  rxc_cfg_reg #(.REG_ID(6'h03)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .dma_only   (dma_only),
    .rd_data    (cfg_rd_data),
    .cfg        (cfg),
    .skip_pulse (skip_pulse)
  );

  rxc_classify #(
    .LEN_W(LEN_W), .MIN_KEEP(MIN_KEEP), .RUNT_LIM(RUNT_LIM),
    .MAX_LEN(MAX_LEN), .FCS_BYTES(FCS_BYTES)
  ) u_cls (
    .bytes    (eof_bytes),
    .crc_ok   (eof_crc_ok),
    .keep_fcs (cfg.keep_fcs),
    .drop     (drop),
    .flags    (cls_flags),
    .len      (cls_len)
  );

  always_comb begin
    irq_en.good     = cfg.ok_ie && !dma_mode;
    irq_en.crc_err  = cfg.crc_ie;
    irq_en.runt     = cfg.runt_ie;
    irq_en.oversize = cfg.long_ie;
  end

  assign eof_ready = !ov_q || out_ready;
  assign accept    = eof_valid && eof_ready;
  assign keep      = accept && !drop;

  rxc_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (keep),
    .flags   (cls_flags),
    .enables (irq_en),
    .rd      (sts_rd),
    .word    (sts_q),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      len_q <= '0;
      flg_q <= '0;
    end else if (keep) begin
      ov_q  <= 1'b1;
      len_q <= cls_len;
      flg_q <= cls_flags;
    end else if (out_ready) begin
      ov_q  <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_len   = len_q;
  assign out_flags = flg_q;
  assign sts_word  = sts_q;
endmodule

// File: rtl/rx_status_classifier_chk.sv
module rx_status_classifier_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [15:0]      cfg_wr_data,
  input logic [15:0]      cfg_rd_data,
  input logic             dma_only,
  input logic             skip_pulse,
  input logic             eof_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LEN_W-1:0] out_len,
  input logic [3:0]       out_flags,
  input logic             sts_rd,
  input logic             irq
);
  // R1
  cfg_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[5:0] == 6'h03 && cfg_rd_data[15] == 1'b0 && cfg_rd_data[10] == 1'b0
    && cfg_rd_data[9] == 1'b0 && cfg_rd_data[7] == 1'b0 && cfg_rd_data[6] == 1'b0);

  // R2
  skip_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pulse |-> $past(cfg_wr_en && cfg_wr_data[6]));

  // R3
  skip_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pulse |-> !$past(dma_only));

  // R8
  good_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[0] |-> out_flags[3:1] == 3'b000);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(sts_rd));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_flags));

  // R12
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_ready == (!out_valid || out_ready));
endmodule

bind rx_status_classifier rx_status_classifier_chk #(.LEN_W(LEN_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .dma_only    (dma_only),
  .skip_pulse  (skip_pulse),
  .eof_ready   (eof_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_len     (out_len),
  .out_flags   (out_flags),
  .sts_rd      (sts_rd),
  .irq         (irq)
);

// File: tb/test_rx_status_classifier.sv
module test_rx_status_classifier;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [15:0]   cfg_wr_data = '0;
  logic [15:0]   cfg_rd_data;
  logic          dma_only = 1'b0;
  logic          dma_mode = 1'b0;
  logic          skip_pulse;
  logic          eof_valid = 1'b0;
  logic          eof_ready;
  logic [LW-1:0] eof_bytes = '0;
  logic          eof_crc_ok = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [LW-1:0] out_len;
  logic [3:0]    out_flags;
  logic          sts_rd = 1'b0;
  logic [3:0]    sts_word;
  logic          irq;

  int total = 0;
  int bad = 0;
  int matched = 0;
  int pushed = 0;
  bit finished = 1'b0;

  typedef struct packed { logic [LW-1:0] len; logic [3:0] flags; } item_t;
  item_t q[$];

  logic [15:0] cfg_m = 16'h0003;
  logic [3:0]  exp_sts = '0;
  logic [3:0]  exp_pend = '0;

  always #5 clk = ~clk;

  rx_status_classifier i_rx_status_classifier (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] d, input logic blk);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    check(blk ? "R3 skip blocked" : "R2 skip pulse", 32'(skip_pulse), 32'(d[6] && !blk));
    cfg_m = {1'b0, d[14:11], 2'b00, d[8], 8'h03};
    check("R1 cfg readback", 32'(cfg_rd_data), 32'(cfg_m));
    @(negedge clk);
    check("R2 one-shot", 32'(skip_pulse), 0);
  endtask

  task automatic read_sts();
    @(negedge clk);
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
    exp_sts = '0; exp_pend = '0;
    check("R10 sts cleared", 32'(sts_word), 0);
    check("R10 irq cleared", 32'(irq), 0);
  endtask

  task automatic send(input int n, input logic ok, input string req);
    logic [3:0] f;
    logic [3:0] en;
    f[2] = n < 64;
    f[3] = n > 1518;
    f[1] = !ok;
    f[0] = !(f[1] || f[2] || f[3]);
    en = {cfg_m[14], cfg_m[13], cfg_m[12], cfg_m[8] && !dma_mode};
    @(negedge clk);
    eof_valid = 1'b1; eof_bytes = LW'(n); eof_crc_ok = ok;
    #1;
    while (!eof_ready) begin
      @(negedge clk);
      #1;
    end
    if (n >= 8) begin
      q.push_back({LW'(cfg_m[11] ? n : n - 4), f});
      pushed++;
      exp_sts = f;
      exp_pend = exp_pend | (f & en);
    end
    @(posedge clk);
    @(negedge clk);
    eof_valid = 1'b0;
    #1;
    check({req, " sts_word"}, 32'(sts_word), 32'(exp_sts));
    check("R10 irq", 32'(irq), 32'(|exp_pend));
  endtask

  int mon_cyc = 0;
  always @(negedge clk) begin
    out_ready = (mon_cyc % 4) != 3;
    mon_cyc++;
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        check("R12 unexpected item", 32'(out_flags), 32'hFFFF);
      end else begin
        item_t e;
        e = q.pop_front();
        check("R9 out_len", 32'(out_len), 32'(e.len));
        check("R8 out_flags", 32'(out_flags), 32'(e.flags));
        matched++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset cfg", 32'(cfg_rd_data), 32'h0003);
    check("R10 reset irq", 32'(irq), 0);
    check("R12 reset out_valid", 32'(out_valid), 0);
    check("R2 reset skip", 32'(skip_pulse), 0);

    dma_only = 1'b1;
    write_cfg(16'hFFFF, 1'b1);          // R3, R1
    dma_only = 1'b0;
    write_cfg(16'h0043, 1'b0);          // R2
    write_cfg(16'h7103, 1'b0);

    send(100, 1'b1, "R8 good");
    read_sts();
    send(40, 1'b0, "R7 runt+crc");
    send(5, 1'b1, "R4 drop keeps status");
    read_sts();
    send(7, 1'b0, "R4 drop boundary");
    send(8, 1'b1, "R5 runt min");
    send(63, 1'b1, "R5 runt edge");
    send(64, 1'b1, "R8 good edge");
    send(1518, 1'b1, "R6 max good");
    send(1519, 1'b1, "R6 oversize edge");
    send(1600, 1'b0, "R6 oversize bad crc");
    read_sts();
    send(200, 1'b0, "R7 crc error");
    read_sts();

    write_cfg(16'h7903, 1'b0);          // R9 keep FCS
    send(100, 1'b1, "R9 keep fcs");
    send(1600, 1'b1, "R9 keep fcs long");
    read_sts();

    write_cfg(16'h0103, 1'b0);
    dma_mode = 1'b1;
    send(300, 1'b1, "R11 dma good");
    dma_mode = 1'b0;
    send(300, 1'b1, "R11 non-dma good");
    read_sts();

    write_cfg(16'h0003, 1'b0);
    send(90, 1'b0, "R10 no enable");

    repeat (20) @(negedge clk);
    check("R12 all items out", 32'(matched), 32'(pushed));
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule